// File: doc/BRIEF.md
# Stereo Soft Mute Gain Ramp

This block sits in a digital audio path and scales a stream of stereo PCM words. Each transfer carries one signed 24-bit left sample and one signed 24-bit right sample. Both are multiplied by a shared gain index and divided by the ramp length, which defaults to 1024. A mute request input moves the index toward zero, one step per frame tick. The frame tick is a single-cycle pulse derived from the word clock. When the request drops, the index climbs back to unity at the same rate.

The sample stream keeps flowing during a ramp, so a source can be swapped without a click. A ramp that is interrupted reverses direction from the index it has reached. It does not jump to either end.

Samples enter and leave through valid/ready handshakes with a single register stage. `in_ready` is high whenever the output register is empty or being drained in the same cycle. Otherwise the upstream producer must hold its word. While `out_valid` is high and `out_ready` is low, the output word stays frozen.

Top module: `soft_mute_ramp`

## Requirements
- R1: A synchronous reset (`rst_n` low at a clock edge) sets the gain index to the ramp length (unity), clears `out_valid` and drives both output samples to 0.
- R2: While `mute_req` is high, each `frame_tick` lowers the index by one. The index reaches 0 after 1024 ticks from unity and stays at 0 while the request holds. Samples accepted at index 0 leave as 0.
- R3: While `mute_req` is low, each `frame_tick` raises the index by one. The index stops at 1024.
- R4: A change of `mute_req` partway through a ramp reverses the direction from the index reached. The ramp does not restart from an end point.
- R5: An accepted sample leaves as sample × index / 1024, rounded toward zero. Both channels use the same index: the value held before any tick in the accepting cycle.
- R6: `muted` is high exactly when the index is 0 and `mute_req` is high, in the same cycle.
- R7: A word accepted when `in_valid` and `in_ready` are both high appears on the outputs in the next cycle with `out_valid` high. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the outputs hold.
- R8: The index changes only on `frame_tick` cycles. It advances whether or not samples are flowing.
- R9: At unity gain every sample, including -8388608 and 8388607, passes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_tick | input | 1 | One-cycle pulse per audio frame |
| mute_req | input | 1 | High requests a ramp to silence, low a ramp to unity |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take an input word this cycle |
| in_left | input | 24 | Left sample, two's complement |
| in_right | input | 24 | Right sample, two's complement |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream takes the output word this cycle |
| out_left | output | 24 | Scaled left sample |
| out_right | output | 24 | Scaled right sample |
| muted | output | 1 | Index at 0 with the mute request held |

## Verification
A scaled word is due one clock after it is accepted. It uses the index as it stood before that edge's tick. A tick moves the index at the same edge, so the tick first shows in words accepted in the next cycle. `muted` and `in_ready` are combinational and are due in the cycle their inputs change. The bench drives every input at the falling edge. Its model moves to the state each register should hold after the coming rising edge, and the bench compares the ports against the model one falling edge later. The probes feed ±1024 through a drained stage with no tick, so the value read back two falling edges later equals the exact index.

// File: rtl/sm_pkg.sv
package sm_pkg;

  // Direction the gain index moves on the next frame tick
  typedef enum logic [1:0] {
    RAMP_HOLD = 2'd0,
    RAMP_DOWN = 2'd1,
    RAMP_UP   = 2'd2
  } ramp_dir_e;

  // Number of index bits needed for a ramp of 'steps' (inclusive of the end point)
  function automatic int idx_width(input int steps);
    return $clog2(steps) + 1;
  endfunction

endpackage

// File: rtl/sm_gain_ctrl.sv
module sm_gain_ctrl
  import sm_pkg::*;
#(
  parameter int STEPS = 1024,
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_tick,
  input  logic             mute_req,
  output logic [IDX_W-1:0] gain_idx,
  output logic             at_floor
);

  localparam logic [IDX_W-1:0] TOP = IDX_W'(STEPS);

  ramp_dir_e dir;

  // Pick a direction from the request and the end stops
  always_comb begin
    dir = RAMP_HOLD;
    if (mute_req) begin
      if (gain_idx != '0) dir = RAMP_DOWN;
    end else begin
      if (gain_idx != TOP) dir = RAMP_UP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gain_idx <= TOP;
    end else if (frame_tick) begin
      unique case (dir)
        RAMP_DOWN: gain_idx <= gain_idx - 1'b1;
        RAMP_UP:   gain_idx <= gain_idx + 1'b1;
        default:   gain_idx <= gain_idx;
      endcase
    end
  end

  assign at_floor = (gain_idx == '0);

endmodule

// File: rtl/sm_scale_lane.sv
module sm_scale_lane #(
  parameter int DATA_W = 24,
  parameter int IDX_W  = 11,
  parameter int SHIFT  = 10
) (
  input  logic signed [DATA_W-1:0] sample,
  input  logic        [IDX_W-1:0]  gain_idx,
  output logic signed [DATA_W-1:0] scaled
);

  localparam int PW = DATA_W + IDX_W + 1;

  logic signed [PW-1:0] s_ext;
  logic signed [PW-1:0] g_ext;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] bias;
  logic signed [PW-1:0] shifted;

  always_comb begin
    s_ext   = PW'(sample);
    g_ext   = $signed({{(PW-IDX_W){1'b0}}, gain_idx});
    prod    = s_ext * g_ext;
    // Negative products get a bias so the arithmetic shift truncates toward zero
    bias    = prod[PW-1] ? PW'((1 << SHIFT) - 1) : '0;
    shifted = (prod + bias) >>> SHIFT;
    scaled  = shifted[DATA_W-1:0];
  end

endmodule

// File: rtl/sm_out_stage.sv
module sm_out_stage #(
  parameter int DATA_W = 24,
  parameter int LANES  = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [LANES-1:0][DATA_W-1:0]  in_data,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [LANES-1:0][DATA_W-1:0]  out_data
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        out_data[g] <= '0;
      end else if (in_valid && in_ready) begin
        out_data[g] <= in_data[g];
      end
    end
  end

endmodule

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp
  import sm_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int STEPS  = 1024
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frame_tick,
  input  logic                     mute_req,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] in_left,
  input  logic signed [DATA_W-1:0] in_right,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [DATA_W-1:0] out_left,
  output logic signed [DATA_W-1:0] out_right,
  output logic                     muted
);

  localparam int IDX_W = idx_width(STEPS);
  localparam int SHIFT = $clog2(STEPS);
  localparam int LANES = 2;

  logic [IDX_W-1:0]             gain_idx;
  logic                         at_floor;
  logic [LANES-1:0][DATA_W-1:0] lane_in;
  logic [LANES-1:0][DATA_W-1:0] lane_scaled;
  logic [LANES-1:0][DATA_W-1:0] lane_out;

  sm_gain_ctrl #(
    .STEPS (STEPS),
    .IDX_W (IDX_W)
  ) u_gain (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_tick (frame_tick),
    .mute_req   (mute_req),
    .gain_idx   (gain_idx),
    .at_floor   (at_floor)
  );

  assign lane_in[0] = in_left;
  assign lane_in[1] = in_right;

  for (genvar g = 0; g < LANES; g++) begin : g_scale
    logic signed [DATA_W-1:0] res;
    sm_scale_lane #(
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W),
      .SHIFT  (SHIFT)
    ) u_lane (
      .sample   ($signed(lane_in[g])),
      .gain_idx (gain_idx),
      .scaled   (res)
    );
    assign lane_scaled[g] = res;
  end

  sm_out_stage #(
    .DATA_W (DATA_W),
    .LANES  (LANES)
  ) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (lane_scaled),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (lane_out)
  );

  assign out_left  = $signed(lane_out[0]);
  assign out_right = $signed(lane_out[1]);
  assign muted     = at_floor && mute_req;

endmodule

// File: rtl/sm_checker.sv
module sm_checker #(
  parameter int DATA_W = 24,
  parameter int IDX_W  = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_tick,
  input logic              mute_req,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_left,
  input logic [DATA_W-1:0] out_right,
  input logic              muted,
  input logic [IDX_W-1:0]  gain_idx
);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_left) && $stable(out_right)));

  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_silence_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (muted && in_valid && in_ready) |=> (out_left == '0 && out_right == '0));

  p_stay_muted_r2: assert property (@(posedge clk) disable iff (!rst_n)
    muted |=> (!mute_req || muted));

  p_flag_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mute_req |-> !muted);

  p_tick_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(gain_idx));

endmodule

bind soft_mute_ramp sm_checker #(
  .DATA_W (DATA_W),
  .IDX_W  (IDX_W)
) u_sm_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_tick (frame_tick),
  .mute_req   (mute_req),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_left   (out_left),
  .out_right  (out_right),
  .muted      (muted),
  .gain_idx   (gain_idx)
);

// File: tb/tb_soft_mute_ramp.sv
module tb_soft_mute_ramp;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_tick = 1'b0;
  logic mute_req = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic signed [23:0] in_left = '0;
  logic signed [23:0] in_right = '0;
  logic in_ready, out_valid, muted;
  logic signed [23:0] out_left, out_right;

  always #5 clk = ~clk;

  soft_mute_ramp dut (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .mute_req(mute_req),
    .in_valid(in_valid), .in_ready(in_ready), .in_left(in_left), .in_right(in_right),
    .out_valid(out_valid), .out_ready(out_ready), .out_left(out_left),
    .out_right(out_right), .muted(muted)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Reference model state: register values after the last rising edge
  int m_idx = 1024;
  bit m_valid = 0;
  logic signed [23:0] m_l = '0;
  logic signed [23:0] m_r = '0;

  function automatic logic signed [23:0] mscale(input logic signed [23:0] s, input int idx);
    longint p;
    p = longint'(s) * idx;
    return 24'(p / 1024);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive at the falling edge, compare, then advance the model to the next edge
  task automatic step(input bit tick, input bit vld, input logic signed [23:0] l,
                      input logic signed [23:0] r, input bit rdy, input bit req);
    bit exp_ready;
    bit acc;
    @(negedge clk);
    frame_tick = tick; in_valid = vld; in_left = l; in_right = r;
    out_ready = rdy; mute_req = req;
    #1;
    exp_ready = !m_valid || rdy;
    chk(out_valid == m_valid, "R7 out_valid", out_valid, m_valid);
    chk(in_ready == exp_ready, "R7 in_ready", in_ready, exp_ready);
    chk(out_left == m_l, "R5 out_left", out_left, m_l);
    chk(out_right == m_r, "R5 out_right", out_right, m_r);
    chk(muted == (m_idx == 0 && req), "R6 muted", muted, (m_idx == 0 && req));
    acc = vld && exp_ready;
    if (exp_ready) m_valid = vld;
    if (acc) begin
      m_l = mscale(l, m_idx);
      m_r = mscale(r, m_idx);
    end
    if (tick) begin
      if (req && m_idx > 0) m_idx--;
      else if (!req && m_idx < 1024) m_idx++;
    end
  endtask

  function automatic logic signed [23:0] pick_sample();
    int k;
    k = $urandom_range(0, 9);
    if (k == 0) return 24'sh800000;
    if (k == 1) return 24'sh7FFFFF;
    if (k == 2) return -24'sd1;
    return 24'($urandom);
  endfunction

  // Run with random traffic until n frame ticks have been issued
  task automatic run_ticks(input int n, input bit req, input bit traffic);
    int ticks;
    ticks = 0;
    for (int c = 0; ticks < n; c++) begin
      bit t;
      t = (c % 4) == 3;
      step(t, traffic && ($urandom_range(0, 3) != 0), pick_sample(), pick_sample(),
           $urandom_range(0, 2) != 0, req);
      if (t) ticks++;
    end
  endtask

  // Feed +/-1024 with no tick; after draining, the output equals the index
  task automatic probe(input int exp, input bit req, input string req_tag);
    step(1'b0, 1'b1, 24'sd1024, -24'sd1024, 1'b1, req);
    step(1'b0, 1'b0, 24'sd0, 24'sd0, 1'b0, req);
    chk(out_left == exp, req_tag, out_left, exp);
    chk(out_right == -exp, req_tag, out_right, -exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset values
    chk(out_valid == 0, "R1 out_valid", out_valid, 0);
    chk(out_left == 0 && out_right == 0, "R1 data", out_left, 0);
    chk(muted == 0, "R1 muted", muted, 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R9 unity pass-through including extremes
    step(1'b0, 1'b1, 24'sh800000, 24'sh7FFFFF, 1'b1, 1'b0);
    step(1'b0, 1'b0, 24'sd0, 24'sd0, 1'b1, 1'b0);
    chk(out_left == 24'sh800000, "R9 min", out_left, -8388608);
    chk(out_right == 24'sh7FFFFF, "R9 max", out_right, 8388607);
    probe(1024, 1'b0, "R1 unity index");
    run_ticks(50, 1'b0, 1'b1);
    probe(1024, 1'b0, "R3 saturate at unity");
    // R2 full mute ramp
    run_ticks(1030, 1'b1, 1'b1);
    probe(0, 1'b1, "R2 silent after ramp");
    chk(muted == 1, "R6 muted flag", muted, 1);
    // R3 ramp up partway
    run_ticks(300, 1'b0, 1'b1);
    probe(300, 1'b0, "R3 partial up");
    // R4 reversals from the reached index
    run_ticks(100, 1'b1, 1'b1);
    probe(200, 1'b1, "R4 reverse down");
    run_ticks(50, 1'b0, 1'b1);
    probe(250, 1'b0, "R4 reverse up");
    // R5 rounding toward zero at a fractional gain
    step(1'b0, 1'b1, -24'sd1000, 24'sd1000, 1'b1, 1'b0);
    step(1'b0, 1'b0, 24'sd0, 24'sd0, 1'b1, 1'b0);
    chk(out_left == -24'sd244, "R5 neg trunc", out_left, -244);
    chk(out_right == 24'sd244, "R5 pos trunc", out_right, 244);
    run_ticks(800, 1'b0, 1'b1);
    probe(1024, 1'b0, "R3 back to unity");
    // R8 ticks move the gain with no traffic
    run_ticks(10, 1'b1, 1'b0);
    probe(1014, 1'b1, "R8 idle ticks");
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule